// File: doc/BRIEF.md
# Store Queue with Single-Match Forwarding

This block buffers the stores of a speculative core in program order and lets loads pick up store data before the stores reach memory. It does this without any age-priority selection. The rule that makes this possible is applied when a store issues: the store turns off forwarding from every older entry that holds the same 8-byte word. After that, each word address has at most one entry that can respond. A load search is therefore an equality compare in every entry, followed by an OR of the single selected entry's data.

Slots are taken at the tail when a store is dispatched. The slot index goes back to the core, which later issues the store into that slot with its address, byte mask and data. Stores may issue out of order. Issued stores leave from the head, in order, through a drain stream toward the cache. Entries that have been disabled still drain, because only their forwarding is turned off.

Matching compares virtual word addresses with no translation, so two virtual names for the same physical location are not detected. The block keeps no load-side record, so it cannot detect or replay ordering violations. A recovery flush empties the queue in one cycle.

Top module: `sq_fwd_top`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0, `drain_valid` is 0, and no search port reports a hit.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` both high) returns the current tail slot on `alloc_idx`. Slots are handed out as 0, 1, 2 and so on, modulo DEPTH. When DEPTH entries are held, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R3: When a store issues, every older issued entry with the same word address (address bits above bit 2) stops forwarding. A search then returns the data of the youngest issued store to that word.
- R4: If a store issues after a younger store to the same word has already issued, the older store never forwards. The younger one keeps responding.
- R5: For any search address, at most one entry matches.
- R6: A hit needs word equality and a store byte mask that covers every bit set in the load byte mask. If the responding store covers only part of the load, the search misses, even if an older store to that word covers the whole load.
- R7: The two search ports are independent and are both evaluated in the same cycle. Port p uses slice p of `ld_addr`, `ld_mask` and `ld_data`.
- R8: A search is combinational against the state held at the start of the cycle. A store that issues in a cycle becomes visible to searches from the next cycle.
- R9: `drain_valid` is high exactly when the head entry has issued. It presents that entry's word address (with bits 2:0 set to zero), byte mask and data. The entry leaves only when `drain_ready` is high. While `drain_ready` is low, the presented values are held. Disabled entries drain like any other entry.
- R10: `flush` empties the queue in one cycle and resets the tail slot to 0. It takes priority over any allocation, issue or drain in the same cycle.
- R11: Address bits 2:0 of both stores and loads are ignored when matching.
- R12: Entries that are not allocated, or allocated but not yet issued, never match a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Recovery flush, empties the queue |
| alloc_valid | input | 1 | Request for a slot at the tail |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_idx | output | $clog2(DEPTH) | Slot given to the accepted allocation |
| iss_valid | input | 1 | Store issue into slot `iss_idx` |
| iss_idx | input | $clog2(DEPTH) | Slot being issued |
| iss_addr | input | ADDR_W | Store virtual address |
| iss_mask | input | 8 | Store byte mask within the word |
| iss_data | input | 64 | Store data |
| ld_valid | input | NPORT | Per-port search request |
| ld_addr | input | NPORT*ADDR_W | Per-port load virtual address |
| ld_mask | input | NPORT*8 | Per-port load byte mask |
| ld_hit | output | NPORT | Per-port forward hit |
| ld_data | output | NPORT*64 | Per-port forwarded word |
| drain_valid | output | 1 | Head store ready to leave |
| drain_ready | input | 1 | Cache accepts the head store |
| drain_addr | output | ADDR_W | Head store word address |
| drain_mask | output | 8 | Head store byte mask |
| drain_data | output | 64 | Head store data |

## Verification
The bench builds the queue with DEPTH 32, two search ports and a 32-bit address. This is deep enough that filling the queue and wrapping the pointers both happen within a few hundred cycles. Store and load addresses come from a pool of four words, with random bits 2:0. This makes same-word collisions, out-of-order issues into shared words and partial-mask overlaps occur all the time, rather than as rare events.

// File: rtl/sq_pkg.sv
package sq_pkg;
  parameter int unsigned SQ_DATA_W = 64;
  parameter int unsigned SQ_MASK_W = 8;
  parameter int unsigned SQ_OFS_W  = 3;
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full
);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/sq_search.sv
module sq_search
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WA_W   = 45
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [DEPTH-1:0]                   ent_fwd,
  input  logic [DEPTH-1:0][WA_W-1:0]         ent_word,
  input  logic [DEPTH-1:0][SQ_MASK_W-1:0]    ent_mask,
  input  logic [DEPTH-1:0][SQ_DATA_W-1:0]    ent_data,
  input  logic                               ld_valid,
  input  logic [WA_W-1:0]                    ld_word,
  input  logic [SQ_MASK_W-1:0]               ld_mask,
  output logic                               hit,
  output logic [SQ_DATA_W-1:0]               data
);
  logic [DEPTH-1:0]     match;
  logic [SQ_MASK_W-1:0] sel_mask;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign match[e] = ent_fwd[e] && (ent_word[e] == ld_word);
  end

  always_comb begin
    sel_mask = '0;
    data     = '0;
    for (int e = 0; e < DEPTH; e++) begin
      sel_mask = sel_mask | (ent_mask[e] & {SQ_MASK_W{match[e]}});
      data     = data     | (ent_data[e] & {SQ_DATA_W{match[e]}});
    end
  end

  assign hit = ld_valid && (|match) && ((ld_mask & ~sel_mask) == '0);

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/sq_fwd_top.sv
module sq_fwd_top
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned NPORT  = 2,
  parameter int unsigned ADDR_W = 48
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            alloc_valid,
  output logic                            alloc_ready,
  output logic [$clog2(DEPTH)-1:0]        alloc_idx,
  input  logic                            iss_valid,
  input  logic [$clog2(DEPTH)-1:0]        iss_idx,
  input  logic [ADDR_W-1:0]               iss_addr,
  input  logic [7:0]                      iss_mask,
  input  logic [63:0]                     iss_data,
  input  logic [NPORT-1:0]                ld_valid,
  input  logic [NPORT*ADDR_W-1:0]         ld_addr,
  input  logic [NPORT*8-1:0]              ld_mask,
  output logic [NPORT-1:0]                ld_hit,
  output logic [NPORT*64-1:0]             ld_data,
  output logic                            drain_valid,
  input  logic                            drain_ready,
  output logic [ADDR_W-1:0]               drain_addr,
  output logic [7:0]                      drain_mask,
  output logic [63:0]                     drain_data
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned WA_W  = ADDR_W - SQ_OFS_W;

  logic [DEPTH-1:0]                 ent_alloc, ent_iss, ent_live;
  logic [DEPTH-1:0][WA_W-1:0]       ent_word;
  logic [DEPTH-1:0][SQ_MASK_W-1:0]  ent_mask;
  logic [DEPTH-1:0][SQ_DATA_W-1:0]  ent_data;
  logic [IDX_W-1:0]                 head, tail;
  logic                             full, push, pop, iss_ok, young_same;
  logic [DEPTH-1:0]                 kill;
  logic [IDX_W-1:0]                 age_new;
  logic [WA_W-1:0]                  iss_word;
  logic                             unused_low;

  assign iss_word    = iss_addr[ADDR_W-1:SQ_OFS_W];
  assign alloc_ready = !full;
  assign alloc_idx   = tail;
  assign push        = alloc_valid && !full && !flush;
  assign drain_valid = ent_alloc[head] && ent_iss[head];
  assign pop         = drain_valid && drain_ready && !flush;
  assign drain_addr  = {ent_word[head], {SQ_OFS_W{1'b0}}};
  assign drain_mask  = ent_mask[head];
  assign drain_data  = ent_data[head];

  sq_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .head(head), .tail(tail), .full(full)
  );

  // Issue-time disable: older same-word entries lose their forwarding right;
  // a younger same-word entry already live keeps it, so the new one stays dark.
  always_comb begin
    iss_ok     = iss_valid && ent_alloc[iss_idx] && !ent_iss[iss_idx] && !flush;
    age_new    = iss_idx - head;
    young_same = 1'b0;
    kill       = '0;
    for (int j = 0; j < DEPTH; j++) begin
      logic             same;
      logic [IDX_W-1:0] age_j;
      age_j = IDX_W'(j) - head;
      same  = ent_iss[j] && ent_live[j] && (ent_word[j] == iss_word)
              && (IDX_W'(j) != iss_idx);
      if (iss_ok && same && (age_j < age_new)) kill[j] = 1'b1;
      if (iss_ok && same && (age_j > age_new)) young_same = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ent_alloc <= '0;
      ent_iss   <= '0;
      ent_live  <= '0;
    end else begin
      ent_live <= ent_live & ~kill;
      if (pop) begin
        ent_alloc[head] <= 1'b0;
        ent_iss[head]   <= 1'b0;
        ent_live[head]  <= 1'b0;
      end
      if (iss_ok) begin
        ent_iss[iss_idx]  <= 1'b1;
        ent_live[iss_idx] <= !young_same;
      end
      if (push) begin
        ent_alloc[tail] <= 1'b1;
        ent_iss[tail]   <= 1'b0;
        ent_live[tail]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (iss_ok) begin
      ent_word[iss_idx] <= iss_word;
      ent_mask[iss_idx] <= iss_mask;
      ent_data[iss_idx] <= iss_data;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sq_search #(.DEPTH(DEPTH), .WA_W(WA_W)) u_search (
      .clk(clk), .rst_n(rst_n),
      .ent_fwd(ent_iss & ent_live & ent_alloc),
      .ent_word(ent_word), .ent_mask(ent_mask), .ent_data(ent_data),
      .ld_valid(ld_valid[p]),
      .ld_word(ld_addr[p*ADDR_W+SQ_OFS_W +: WA_W]),
      .ld_mask(ld_mask[p*8 +: 8]),
      .hit(ld_hit[p]),
      .data(ld_data[p*64 +: 64])
    );
  end

  always_comb begin
    unused_low = ^iss_addr[SQ_OFS_W-1:0];
    for (int p = 0; p < NPORT; p++)
      unused_low = unused_low ^ (^ld_addr[p*ADDR_W +: SQ_OFS_W]);
  end

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!drain_valid && alloc_ready && (alloc_idx == '0)));
  a_r9_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready && !flush) |=>
      (drain_valid && $stable(drain_data) && $stable(drain_addr) && $stable(drain_mask)));
  a_r8_issue_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_ok && !young_same) |=> ent_live[$past(iss_idx)]);
endmodule

// File: tb/sq_fwd_top_test.sv
`timescale 1ns/1ps
module sq_fwd_top_test;
  localparam int DEPTH = 32;
  localparam int NPORT = 2;
  localparam int AW    = 32;
  localparam int IW    = $clog2(DEPTH);

  typedef struct {
    int          idx;
    bit          iss;
    logic [AW-1:0] addr;
    logic [7:0]  mask;
    logic [63:0] data;
  } ent_t;

  logic clk = 0, rst_n = 0, flush = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic iss_valid = 0;
  logic [IW-1:0] iss_idx = '0;
  logic [AW-1:0] iss_addr = '0;
  logic [7:0] iss_mask = '0;
  logic [63:0] iss_data = '0;
  logic [NPORT-1:0] ld_valid = '0;
  logic [NPORT*AW-1:0] ld_addr = '0;
  logic [NPORT*8-1:0] ld_mask = '0;
  logic [NPORT-1:0] ld_hit;
  logic [NPORT*64-1:0] ld_data;
  logic drain_valid, drain_ready = 0;
  logic [AW-1:0] drain_addr;
  logic [7:0] drain_mask;
  logic [63:0] drain_data;

  ent_t mq[$];
  int mtail = 0, nchk = 0, nfail = 0, cyc = 0;
  string cur_req = "R1";
  logic [AW-1:0] pool [4];

  sq_fwd_top #(.DEPTH(DEPTH), .NPORT(NPORT), .ADDR_W(AW)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++; nchk++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; alloc_valid = 0; iss_valid = 0; ld_valid = '0; drain_ready = 0;
  endtask

  task automatic tick();
    bit er, edv, fal, fdr, fis, ffl;
    #1;
    er  = mq.size() < DEPTH;
    chk(alloc_ready == er, "R2", "alloc_ready", 64'(alloc_ready), 64'(er));
    if (er) chk(alloc_idx == IW'(mtail), "R2", "alloc_idx", 64'(alloc_idx), 64'(mtail));
    edv = (mq.size() > 0) && mq[0].iss;
    chk(drain_valid == edv, "R9", "drain_valid", 64'(drain_valid), 64'(edv));
    if (edv) begin
      chk(drain_addr == {mq[0].addr[AW-1:3], 3'b000}, "R9", "drain_addr",
          64'(drain_addr), 64'({mq[0].addr[AW-1:3], 3'b000}));
      chk(drain_mask == mq[0].mask, "R9", "drain_mask", 64'(drain_mask), 64'(mq[0].mask));
      chk(drain_data == mq[0].data, "R9", "drain_data", drain_data, mq[0].data);
    end
    for (int p = 0; p < NPORT; p++) begin
      bit eh = 0; logic [63:0] ed = '0; bit found = 0;
      logic [AW-1:0] la = ld_addr[p*AW +: AW];
      logic [7:0] lm = ld_mask[p*8 +: 8];
      for (int k = mq.size() - 1; k >= 0; k--) begin
        if (!found && mq[k].iss && mq[k].addr[AW-1:3] == la[AW-1:3]) begin
          found = 1;
          eh = ld_valid[p] && ((lm & ~mq[k].mask) == 8'h00);
          ed = mq[k].data;
        end
      end
      chk(ld_hit[p] == eh, cur_req, $sformatf("ld_hit[%0d]", p), 64'(ld_hit[p]), 64'(eh));
      if (eh) chk(ld_data[p*64 +: 64] == ed, cur_req, $sformatf("ld_data[%0d]", p),
                  ld_data[p*64 +: 64], ed);
    end
    ffl = flush; fal = alloc_valid && er; fdr = drain_ready && edv; fis = iss_valid;
    @(posedge clk);
    if (ffl) begin
      mq.delete(); mtail = 0;
    end else begin
      if (fdr) void'(mq.pop_front());
      if (fis) foreach (mq[k]) if (mq[k].idx == int'(iss_idx) && !mq[k].iss) begin
        mq[k].iss = 1; mq[k].addr = iss_addr; mq[k].mask = iss_mask; mq[k].data = iss_data;
      end
      if (fal) begin
        ent_t e; e.idx = mtail; e.iss = 0; e.addr = '0; e.mask = '0; e.data = '0;
        mq.push_back(e); mtail = (mtail + 1) % DEPTH;
      end
    end
    @(negedge clk);
  endtask

  task automatic alloc_one(output int idx);
    idle(); idx = mtail; alloc_valid = 1; tick(); idle();
  endtask

  task automatic issue(int idx, logic [AW-1:0] a, logic [7:0] m, logic [63:0] d);
    idle(); iss_valid = 1; iss_idx = IW'(idx); iss_addr = a; iss_mask = m; iss_data = d;
  endtask

  task automatic load(int p, logic [AW-1:0] a, logic [7:0] m);
    ld_valid[p] = 1; ld_addr[p*AW +: AW] = a; ld_mask[p*8 +: 8] = m;
  endtask

  initial begin
    int i0, i1, i2, i3, i4, i5;
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1008;
    pool[2] = 32'h0004_2040; pool[3] = 32'hFFFF_FFF8;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state with searches active
    cur_req = "R1"; load(0, pool[0], 8'hFF); load(1, pool[1], 8'h01); tick();
    // R3 / R8: younger issue disables older; same-cycle search sees old state
    alloc_one(i0); alloc_one(i1);
    cur_req = "R3"; issue(i0, pool[0], 8'hFF, 64'hAAAA_0000_0000_0001); tick();
    cur_req = "R8"; issue(i1, pool[0] + 3, 8'hFF, 64'hBBBB_0000_0000_0002);
    load(0, pool[0], 8'hFF); tick();
    cur_req = "R3"; idle(); load(0, pool[0], 8'hFF); load(1, pool[0] + 5, 8'h0F); tick();
    // R4: older store issued after younger same-word one stays dark
    alloc_one(i2); alloc_one(i3);
    cur_req = "R4"; issue(i3, pool[1], 8'hFF, 64'h3333); tick();
    issue(i2, pool[1], 8'hFF, 64'h2222); tick();
    idle(); load(0, pool[1], 8'hFF); load(1, pool[1], 8'h80); tick();
    // R6: partial cover misses even with an older full cover
    alloc_one(i4); alloc_one(i5);
    cur_req = "R6"; issue(i4, pool[2], 8'hFF, 64'h4444); tick();
    issue(i5, pool[2], 8'h0F, 64'h5555); tick();
    idle(); load(0, pool[2], 8'hF0); load(1, pool[2], 8'h03); tick();
    // R11: low address bits ignored; R7 both ports at once
    cur_req = "R11"; idle(); load(0, pool[2] + 7, 8'h01); load(1, pool[0] + 1, 8'hFF); tick();
    // R12: unissued entry never matches
    alloc_one(i0); cur_req = "R12"; idle(); load(0, pool[3], 8'h00); tick();
    // R9: stall then drain issued head entries
    idle(); drain_ready = 0; tick(); tick();
    drain_ready = 1; repeat (6) tick();
    // R2: fill to full, extra request ignored
    cur_req = "R2";
    while (mq.size() < DEPTH) begin int k; alloc_one(k); end
    idle(); alloc_valid = 1; tick(); tick();
    // R10: flush with allocation and issue in the same cycle
    cur_req = "R10"; idle(); flush = 1; alloc_valid = 1; iss_valid = 1; iss_idx = IW'(mq[DEPTH-1].idx);
    iss_addr = pool[0]; iss_mask = 8'hFF; iss_data = 64'h77; tick();
    idle(); load(0, pool[0], 8'hFF); tick();
    // R7: random traffic on both ports
    cur_req = "R7";
    for (int c = 0; c < 4000; c++) begin
      int pick[$];
      idle();
      alloc_valid = ($urandom % 3) != 0;
      drain_ready = ($urandom % 4) != 0;
      foreach (mq[k]) if (!mq[k].iss) pick.push_back(mq[k].idx);
      if (pick.size() > 0 && ($urandom % 2)) begin
        iss_valid = 1; iss_idx = IW'(pick[$urandom % pick.size()]);
        iss_addr = pool[$urandom % 4] | AW'($urandom % 8);
        iss_mask = ($urandom % 2) ? 8'hFF : 8'(1 << ($urandom % 8)) | 8'h0F;
        iss_data = {$urandom, $urandom};
      end
      for (int p = 0; p < NPORT; p++)
        if ($urandom % 4 != 0) load(p, pool[$urandom % 4] | AW'($urandom % 8), 8'($urandom));
      flush = ($urandom % 250) == 0;
      tick();
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule